// File: doc/BRIEF.md
# Vectored Interrupt Controller with Sorted Winner Register

This block collects 96 level-sensitive interrupt lines, arranged as three groups of 32, and presents a single request line to the processor. Software reaches it through a plain 32-bit register bus: byte address, write enable, write data and read data. Read data is registered and appears one clock after the address is presented. Writes take effect on the clock edge where write enable is high.

Each line has a mask bit. A group's mask bits can be written directly, or changed with write-one-to-set and write-one-to-clear ports. Each line also has a priority register. A global threshold sets the level that a request must exceed before it reaches the processor. The controller picks the winning line: it is the unmasked, asserted line with the largest priority value. The controller latches the winner into a sorted register, which software reads to learn which line to service. The latched number stays frozen until software writes the acknowledge bit. If the latched line is no longer valid when the register is read, the read is flagged as spurious.

A software-started soft reset returns every register to its reset value, and a status bit shows when the reset has finished. The remaining registers are small configuration stores: an auto-idle enable, a protection bit and an idle field. Software can read each of them back so that it can save its state and restore it later.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all three mask registers (byte addresses 0x84, 0xA4 and 0xC4) read 0xFFFFFFFF and `irq_o` is low. The status register at 0x14 reads 1 in bit 0. The revision register at 0x00 reads {REV_MAJOR in bits 7:4, REV_MINOR in bits 3:0}, which is 0x21 by default. Read data appears on `rdata_o` one clock after `addr_i`, and an unmapped address reads 0.
- R2: Source n belongs to group g = n/32 at bit n mod 32. Group g's registers sit at 0x84 + 0x20·g (mask), 0x88 + 0x20·g (clear) and 0x8C + 0x20·g (set). Writing 1s to the set register sets those mask bits, and writing 1s to the clear register clears them. Zero bits in either write leave the mask unchanged. The mask register can also be written directly. A masked source never raises `irq_o`.
- R3: The pending register at 0x98 + 0x20·g returns the raw input levels of group g, whatever the mask holds.
- R4: Source n's priority register is at 0x100 + 4·n. Bits 5:0 are read/write and the upper bits read 0.
- R5: The winner is the unmasked, asserted source with the largest priority value. When two sources have equal priority, the lower source number wins.
- R6: The threshold register at 0x68 is read/write in bits 5:0. `irq_o` goes high one clock after the winner's priority becomes strictly greater than the threshold, and goes low one clock after this no longer holds.
- R7: When no winner is held and a qualifying winner exists, its number is latched into the sorted register at 0x40, bits 6:0. The latched number does not change until a write of 1 to bit 0 of the control register at 0x48. After that write the controller latches a new winner.
- R8: A read of the sorted register is spurious when no winner is held, or when the held source is no longer both unmasked and asserted. A spurious read returns bits 31:7 all ones and the held number in bits 6:0. A valid read returns bits 31:7 as zero.
- R9: Writing 1 to bit 1 of the config register at 0x10 resets every register on the next clock. During that clock the status register reads 0 in bit 0, and on the following clock it reads 1. Bit 1 of the config register always reads 0.
- R10: The following fields are read/write, and any other bits written to these registers read back as 0: config bit 0 (auto-idle), protection register 0x4C bit 0, and idle register 0x50 bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 12 | Byte address of the register access |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for the previous cycle's address |
| src_i | input | 96 | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The checker runs on every cycle and checks the following:
- after reset, every source is masked;
- set and clear writes move the mask bit they target;
- a request on `irq_o` always follows some unmasked, asserted source;
- a held winner stays frozen until it is acknowledged;
- a soft reset masks everything and drops the held winner.

Other behaviours can only be shown by the bench's scenarios, because each needs a chosen mix of inputs and register values:
- the ordering between priority and source number;
- re-latching after an acknowledge;
- the spurious flag when the serviced line drops;
- the effect of the threshold;
- the one-clock window in which the status bit reads 0 during a soft reset.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int OFS_REV     = 'h000;
  localparam int OFS_CFG     = 'h010;
  localparam int OFS_STAT    = 'h014;
  localparam int OFS_SORT    = 'h040;
  localparam int OFS_CTRL    = 'h048;
  localparam int OFS_PROT    = 'h04C;
  localparam int OFS_IDLE    = 'h050;
  localparam int OFS_THR     = 'h068;
  localparam int OFS_MASK    = 'h084;
  localparam int OFS_MCLR    = 'h088;
  localparam int OFS_MSET    = 'h08C;
  localparam int OFS_PEND    = 'h098;
  localparam int BANK_STRIDE = 'h020;
  localparam int OFS_PRIO    = 'h100;
  localparam int SORT_ID_W   = 7;

  typedef struct packed {
    logic wr_mask;
    logic wr_clr;
    logic wr_set;
  } bank_wr_t;
endpackage

// File: rtl/vic_mask_bank.sv
module vic_mask_bank
  import vic_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  bank_wr_t     wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)               mask_o <= '1;
    else if (wr_i.wr_mask)   mask_o <= wdata_i;
    else if (wr_i.wr_clr)    mask_o <= mask_o & ~wdata_i;
    else if (wr_i.wr_set)    mask_o <= mask_o | wdata_i;
  end
endmodule

// File: rtl/vic_prio_file.sv
module vic_prio_file #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            we_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [PW-1:0]   wdata_i,
  output logic [PW-1:0]   rd_o,
  output logic [N*PW-1:0] prio_o
);
  logic [PW-1:0] pr_q [N];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < N; i++) pr_q[i] <= '0;
    end else if (we_i && (int'(idx_i) < N)) begin
      pr_q[idx_i] <= wdata_i;
    end
  end

  always_comb begin
    rd_o = '0;
    if (int'(idx_i) < N) rd_o = pr_q[idx_i];
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign prio_o[g*PW +: PW] = pr_q[g];
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   prio_o
);
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i] && (!any_o || prio_i[i*PW +: PW] >= prio_o)) begin
        any_o  = 1'b1;
        idx_o  = IW'(i);
        prio_o = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int N_SRC     = 96,
  parameter int BANK_W    = 32,
  parameter int PRIO_W    = 6,
  parameter int ADDR_W    = 12,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o
);
  localparam int N_BANK = (N_SRC + BANK_W - 1) / BANK_W;
  localparam int PAD_W  = N_BANK * BANK_W;
  localparam int ID_W   = $clog2(N_SRC);

  logic srst_q;
  logic rst_all;
  assign rst_all = rst_i | srst_q;

  logic [PAD_W-1:0] mask_all;
  logic [PAD_W-1:0] src_pad;
  logic [N_SRC-1:0] cand;
  logic [31:0]      bank_rd [N_BANK];

  assign src_pad = PAD_W'(src_i);
  assign cand    = src_i & ~mask_all[N_SRC-1:0];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    localparam int BOFS = b * BANK_STRIDE;
    bank_wr_t wr;
    assign wr.wr_mask = we_i && (addr_i == ADDR_W'(OFS_MASK + BOFS));
    assign wr.wr_clr  = we_i && (addr_i == ADDR_W'(OFS_MCLR + BOFS));
    assign wr.wr_set  = we_i && (addr_i == ADDR_W'(OFS_MSET + BOFS));

    vic_mask_bank #(.W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_i   (rst_all),
      .wr_i    (wr),
      .wdata_i (wdata_i[BANK_W-1:0]),
      .mask_o  (mask_all[b*BANK_W +: BANK_W])
    );

    always_comb begin
      bank_rd[b] = '0;
      if (addr_i == ADDR_W'(OFS_MASK + BOFS))
        bank_rd[b] = 32'(mask_all[b*BANK_W +: BANK_W]);
      else if (addr_i == ADDR_W'(OFS_PEND + BOFS))
        bank_rd[b] = 32'(src_pad[b*BANK_W +: BANK_W]);
    end
  end

  // priority registers
  logic [ADDR_W-1:0]     poff;
  logic                  prio_hit;
  logic [PRIO_W-1:0]     prio_rd;
  logic [N_SRC*PRIO_W-1:0] prio_flat;

  assign poff     = addr_i - ADDR_W'(OFS_PRIO);
  assign prio_hit = (addr_i >= ADDR_W'(OFS_PRIO)) && (poff[1:0] == 2'b00) &&
                    (int'(poff[ADDR_W-1:2]) < N_SRC);

  vic_prio_file #(.N(N_SRC), .PW(PRIO_W), .IW(ID_W)) u_prio (
    .clk_i   (clk_i),
    .rst_i   (rst_all),
    .we_i    (we_i && prio_hit),
    .idx_i   (poff[ID_W+1:2]),
    .wdata_i (wdata_i[PRIO_W-1:0]),
    .rd_o    (prio_rd),
    .prio_o  (prio_flat)
  );

  // winner selection
  logic              arb_any;
  logic [ID_W-1:0]   arb_idx;
  logic [PRIO_W-1:0] arb_prio;
  logic [PRIO_W-1:0] thr_q;
  logic              qual;

  vic_arbiter #(.N(N_SRC), .PW(PRIO_W), .IW(ID_W)) u_arb (
    .cand_i (cand),
    .prio_i (prio_flat),
    .any_o  (arb_any),
    .idx_o  (arb_idx),
    .prio_o (arb_prio)
  );

  assign qual = arb_any && (arb_prio > thr_q);

  // control and configuration state
  logic            held_q;
  logic [ID_W-1:0] win_q;
  logic            autoidle_q;
  logic            prot_q;
  logic [1:0]      idle_q;
  logic            ack;

  assign ack = we_i && (addr_i == ADDR_W'(OFS_CTRL)) && wdata_i[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) srst_q <= 1'b0;
    else       srst_q <= we_i && (addr_i == ADDR_W'(OFS_CFG)) && wdata_i[1] && !srst_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_all) begin
      held_q     <= 1'b0;
      win_q      <= '0;
      irq_o      <= 1'b0;
      autoidle_q <= 1'b0;
      prot_q     <= 1'b0;
      idle_q     <= '0;
      thr_q      <= '0;
    end else begin
      irq_o <= qual;
      if (ack) begin
        held_q <= 1'b0;
      end else if (!held_q && qual) begin
        held_q <= 1'b1;
        win_q  <= arb_idx;
      end
      if (we_i && addr_i == ADDR_W'(OFS_CFG))  autoidle_q <= wdata_i[0];
      if (we_i && addr_i == ADDR_W'(OFS_PROT)) prot_q     <= wdata_i[0];
      if (we_i && addr_i == ADDR_W'(OFS_IDLE)) idle_q     <= wdata_i[1:0];
      if (we_i && addr_i == ADDR_W'(OFS_THR))  thr_q      <= wdata_i[PRIO_W-1:0];
    end
  end

  // read path
  logic [31:0] rd_nx;
  logic        win_live;
  assign win_live = held_q && cand[win_q];

  always_comb begin
    rd_nx = '0;
    case (addr_i)
      ADDR_W'(OFS_REV):  rd_nx = {24'h0, 4'(REV_MAJOR), 4'(REV_MINOR)};
      ADDR_W'(OFS_CFG):  rd_nx = {31'h0, autoidle_q};
      ADDR_W'(OFS_STAT): rd_nx = {31'h0, ~srst_q};
      ADDR_W'(OFS_SORT): rd_nx = {win_live ? {(32-SORT_ID_W){1'b0}} : {(32-SORT_ID_W){1'b1}},
                                  SORT_ID_W'(win_q)};
      ADDR_W'(OFS_PROT): rd_nx = {31'h0, prot_q};
      ADDR_W'(OFS_IDLE): rd_nx = {30'h0, idle_q};
      ADDR_W'(OFS_THR):  rd_nx = 32'(thr_q);
      default: begin
        for (int b = 0; b < N_BANK; b++) rd_nx = rd_nx | bank_rd[b];
        if (prio_hit) rd_nx = 32'(prio_rd);
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= rd_nx;
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import vic_pkg::*;
#(
  parameter int N_SRC  = 96,
  parameter int PAD_W  = 96,
  parameter int ID_W   = 7,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [N_SRC-1:0]  src_i,
  input logic              irq_o,
  input logic [PAD_W-1:0]  mask_all,
  input logic              held_q,
  input logic [ID_W-1:0]   win_q,
  input logic              srst_q
);
  logic ack_wr, set0_wr, clr0_wr, srst_wr;
  assign ack_wr  = we_i && addr_i == ADDR_W'(OFS_CTRL) && wdata_i[0];
  assign set0_wr = we_i && addr_i == ADDR_W'(OFS_MSET) && wdata_i[0];
  assign clr0_wr = we_i && addr_i == ADDR_W'(OFS_MCLR) && wdata_i[0];
  assign srst_wr = we_i && addr_i == ADDR_W'(OFS_CFG) && wdata_i[1];

  a_r1_masked_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (&mask_all));

  a_r2_set_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
    set0_wr |=> mask_all[0]);

  a_r2_clr_opens: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr0_wr && !srst_q) |=> !mask_all[0]);

  a_r6_irq_needs_source: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> $past(|(src_i & ~mask_all[N_SRC-1:0])));

  a_r7_winner_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    (held_q && !ack_wr && !srst_q) |=> (held_q && $stable(win_q)));

  a_r9_srst_restores: assert property (@(posedge clk_i) disable iff (rst_i)
    (srst_wr && !srst_q) |=> ##1 ((&mask_all) && !held_q));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .N_SRC(N_SRC), .PAD_W(PAD_W), .ID_W(ID_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .src_i(src_i), .irq_o(irq_o), .mask_all(mask_all), .held_q(held_q),
  .win_q(win_q), .srst_q(srst_q)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [95:0] src;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl u0 (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    read_chk("R1 mask g0", 12'h084, 32'hFFFF_FFFF);
    read_chk("R1 mask g1", 12'h0A4, 32'hFFFF_FFFF);
    read_chk("R1 mask g2", 12'h0C4, 32'hFFFF_FFFF);
    read_chk("R1 revision", 12'h000, 32'h0000_0021);
    read_chk("R1 status", 12'h014, 32'h1);
    read_chk("R1 unmapped", 12'h07C, 32'h0);
    check("R1 irq low", {31'h0, irq}, 32'h0);
    read_chk("R8 sorted idle spurious", 12'h040, 32'hFFFF_FF80);
  endtask

  task automatic t_pending;
    src = {32'hA5A5_0F0F, 32'h1234_5678, 32'hDEAD_BEEF};
    idle(2);
    read_chk("R3 pend g0", 12'h098, 32'hDEAD_BEEF);
    read_chk("R3 pend g1", 12'h0B8, 32'h1234_5678);
    read_chk("R3 pend g2", 12'h0D8, 32'hA5A5_0F0F);
    check("R2 masked no irq", {31'h0, irq}, 32'h0);
    src = '0;
    idle(2);
  endtask

  task automatic t_mask;
    bus_write(12'h0A8, 32'h0000_00F0);
    read_chk("R2 clear", 12'h0A4, 32'hFFFF_FF0F);
    bus_write(12'h0AC, 32'h0000_0010);
    read_chk("R2 set", 12'h0A4, 32'hFFFF_FF1F);
    bus_write(12'h0A8, 32'h0);
    read_chk("R2 zero clear", 12'h0A4, 32'hFFFF_FF1F);
    bus_write(12'h0AC, 32'h0);
    read_chk("R2 zero set", 12'h0A4, 32'hFFFF_FF1F);
    bus_write(12'h0A4, 32'h1234_5678);
    read_chk("R2 direct", 12'h0A4, 32'h1234_5678);
    read_chk("R2 g0 untouched", 12'h084, 32'hFFFF_FFFF);
    read_chk("R2 g2 untouched", 12'h0C4, 32'hFFFF_FFFF);
    bus_write(12'h0A4, 32'hFFFF_FFFF);
  endtask

  task automatic t_prio;
    bus_write(12'h100 + 12'(4*95), 32'h2A);
    read_chk("R4 prio 95", 12'h100 + 12'(4*95), 32'h2A);
    bus_write(12'h100 + 12'(4*5), 32'hFFFF_FFFF);
    read_chk("R4 prio width", 12'h100 + 12'(4*5), 32'h3F);
    read_chk("R4 prio 6 zero", 12'h100 + 12'(4*6), 32'h0);
  endtask

  task automatic t_arbitrate;
    bus_write(12'h088, 32'h0000_0408);  // sources 3, 10
    bus_write(12'h0A8, 32'h0000_0100);  // source 40
    bus_write(12'h0C8, 32'h0000_0040);  // source 70
    bus_write(12'h100 + 12'(4*3),  32'd5);
    bus_write(12'h100 + 12'(4*40), 32'd9);
    bus_write(12'h100 + 12'(4*70), 32'd9);
    bus_write(12'h100 + 12'(4*10), 32'd20);
    src[3] = 1'b1; src[40] = 1'b1; src[70] = 1'b1;
    idle(2);
    read_chk("R5 tie lowest", 12'h040, 32'd40);
    check("R6 irq high", {31'h0, irq}, 32'h1);
    src[10] = 1'b1;
    idle(2);
    read_chk("R7 held", 12'h040, 32'd40);
    bus_write(12'h048, 32'h1);
    idle(1);
    read_chk("R7 relatch", 12'h040, 32'd10);
    src[10] = 1'b0;
    idle(1);
    read_chk("R8 spurious", 12'h040, 32'hFFFF_FF8A);
    bus_write(12'h048, 32'h1);
    idle(1);
    read_chk("R5 after ack", 12'h040, 32'd40);
    src[40] = 1'b0;
    bus_write(12'h048, 32'h1);
    idle(1);
    read_chk("R5 next best", 12'h040, 32'd70);
  endtask

  task automatic t_threshold;
    bus_write(12'h068, 32'd9);
    idle(2);
    read_chk("R6 thr readback", 12'h068, 32'd9);
    check("R6 equal blocks", {31'h0, irq}, 32'h0);
    bus_write(12'h068, 32'd8);
    idle(2);
    check("R6 above thr", {31'h0, irq}, 32'h1);
    bus_write(12'h0CC, 32'h0000_0040);
    idle(2);
    check("R2 mask drops irq", {31'h0, irq}, 32'h0);
    bus_write(12'h068, 32'd4);
    idle(2);
    check("R6 low source passes", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_misc;
    bus_write(12'h010, 32'h1);
    read_chk("R10 autoidle", 12'h010, 32'h1);
    bus_write(12'h04C, 32'hFFFF_FFFF);
    read_chk("R10 protection", 12'h04C, 32'h1);
    bus_write(12'h050, 32'hFFFF_FFFF);
    read_chk("R10 idle", 12'h050, 32'h3);
  endtask

  task automatic t_soft_reset;
    bus_write(12'h010, 32'h3);
    read_chk("R9 status busy", 12'h014, 32'h0);
    read_chk("R9 status done", 12'h014, 32'h1);
    read_chk("R9 config cleared", 12'h010, 32'h0);
    read_chk("R9 mask restored", 12'h084, 32'hFFFF_FFFF);
    read_chk("R9 thr restored", 12'h068, 32'h0);
    read_chk("R9 prio restored", 12'h100 + 12'(4*95), 32'h0);
    read_chk("R9 idle restored", 12'h050, 32'h0);
    read_chk("R9 sorted dropped", 12'h040, 32'hFFFF_FF80);
    check("R9 irq low", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; addr = '0; we = 1'b0; wdata = '0; src = '0;
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset;
    t_pending;
    t_mask;
    t_prio;
    t_arbitrate;
    t_threshold;
    t_misc;
    t_soft_reset;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule